// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor that moves data between registers over one shared bus. A read-only microprogram, fixed when the design is built, holds one microinstruction per micro-address. Each microinstruction is one register-to-register transfer: it names the source that drives the bus, the registers that load from it, the ALU operation and the memory strobes. It also carries a next-address type and an absolute target. A micro-program counter (micro-PC) selects the current word. The block drives that word's control bundle out every cycle and picks the next micro-address.

Three plain status inputs steer the sequencing. The instruction opcode is used for a dispatch jump into the routine for each instruction. The zero flag of the A register is used for conditional micro-branches. The busy flag of the memory stretches a step while a slow memory access is still running. The datapath and the memory sit outside this block. Every pin is a plain control or status signal and no stream handshake is involved: the memory's busy flag is the only back-pressure, and the micro-PC holds for as long as that flag stays high on a waiting step.

Top module: `uc_sequencer`

## Requirements
- R1: A synchronous active-high `rst` puts the micro-PC at the fetch entry point, micro-address 0, on the next rising edge, whatever the other inputs are.
- R2: The fetch routine runs 0 -> 1 -> 2 -> 3. The control bundle is `ctrl_o` = 18'h00088 at 0 (PC drives the bus, MA loads), 18'h20401 at 1 (memory drives the bus, IR loads) and 18'h04210 at 3 (ALU computes A+4, PC loads). The bit layout is: 0 load IR, 1 load A, 2 load B, 3 load MA, 4 load PC, 5 register-file write, 6 memory write, 7 register file drives bus, 8 immediate drives bus, 9 ALU drives bus, 10 memory drives bus, [12:11] register select (0 PC, 1 rs, 2 rt, 3 rd), 13 sign-extend the immediate, [16:14] ALU operation (0 add, 1 A+4, 2 sub, 3 and, 4 or, 5 A+B*4, 6 set-less-than, 7 use the function field), 17 memory enable.
- R3: On a memory-wait step (addresses 1, 16 and 21), `busy_i` high holds the micro-PC and `busy_i` low advances it by one. On every other step `busy_i` has no effect.
- R4: At address 3 the next micro-address comes from the opcode: 0 -> 4 (register-register), 4 -> 23 (branch if zero), 5 -> 29 (branch if not zero), 8 -> 7 (add immediate), 13 -> 10 (or immediate), 35 -> 13 (load word), 43 -> 18 (store word). `opcode_i` is ignored at every other address.
- R5: Any other opcode dispatches to the halt address 32. The micro-PC stays there until reset, with `halted_o` = 1 and `ctrl_o` = 0.
- R6: The branch-if-zero routine loads A from rs at 23. At 24 it goes to the taken path at 26 when `zero_i` is 1, and to 25 otherwise. The taken path runs 26 -> 27 -> 28. `zero_i` is ignored outside branch steps.
- R7: The branch-if-not-zero routine loads A at 29. At 30 it goes to 26 when `zero_i` is 0, and to 31 otherwise.
- R8: Every routine's last step (6, 9, 12, 17, 22, 25, 28, 31) returns to micro-address 0.
- R9: The immediate routines load B from the immediate. Add-immediate sign-extends (`ctrl_o` = 18'h02104 at 8) and or-immediate zero-extends (`ctrl_o` = 18'h00104 at 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the instruction register |
| zero_i | input | 1 | A register equals zero |
| busy_i | input | 1 | Memory access still in progress |
| ctrl_o | output | 18 | Control bundle of the current microinstruction |
| upc_o | output | 6 | Current micro-address |
| halted_o | output | 1 | Sequencer is parked in the illegal-opcode halt |

## Verification
The bench targets the busy stretch on the instruction read and on the data read. A sequencer that ignored busy there would fetch stale data, and one that tested busy on every step would stall the fetch address step. Both branch polarities are driven with the flag set and clear, and zero is raised on non-branch steps. An inverted or always-sampled test would then show a wrong micro-address. An undecoded opcode must land in the halt state and stay there under further stimulus, and reset must leave both the halt and a busy spin. Sign versus zero extension of the immediate is checked on the control bundle, because a swapped routine would still sequence correctly.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int unsigned UA_W  = 6;
  localparam int unsigned OPC_W = 6;

  typedef enum logic [2:0] {
    NA_NEXT  = 3'd0,
    NA_SPIN  = 3'd1,
    NA_DISP  = 3'd2,
    NA_BZ    = 3'd3,
    NA_BNZ   = 3'd4,
    NA_FETCH = 3'd5,
    NA_RSVD  = 3'd6,
    NA_HALT  = 3'd7
  } na_e;

  typedef enum logic [1:0] {
    RS_PC = 2'd0,
    RS_RS = 2'd1,
    RS_RT = 2'd2,
    RS_RD = 2'd3
  } rsel_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_INC4 = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_OR   = 3'd4,
    ALU_BRT  = 3'd5,
    ALU_SLT  = 3'd6,
    ALU_FUNC = 3'd7
  } alu_e;

  typedef struct packed {
    logic  mem_en;
    alu_e  alu_op;
    logic  imm_sext;
    rsel_e reg_sel;
    logic  drv_mem;
    logic  drv_alu;
    logic  drv_imm;
    logic  drv_reg;
    logic  mem_wr;
    logic  reg_wr;
    logic  ld_pc;
    logic  ld_ma;
    logic  ld_b;
    logic  ld_a;
    logic  ld_ir;
  } ctrl_t;

  localparam int unsigned CW_W = $bits(ctrl_t);

  typedef struct packed {
    na_e             na;
    logic [UA_W-1:0] tgt;
    ctrl_t           cw;
  } uinst_t;

  // Routine entry points in the microprogram
  localparam logic [UA_W-1:0] UA_FETCH = 6'd0;
  localparam logic [UA_W-1:0] UA_RTYPE = 6'd4;
  localparam logic [UA_W-1:0] UA_ADDI  = 6'd7;
  localparam logic [UA_W-1:0] UA_ORI   = 6'd10;
  localparam logic [UA_W-1:0] UA_LW    = 6'd13;
  localparam logic [UA_W-1:0] UA_SW    = 6'd18;
  localparam logic [UA_W-1:0] UA_BEQZ  = 6'd23;
  localparam logic [UA_W-1:0] UA_BRTK  = 6'd26;
  localparam logic [UA_W-1:0] UA_BNEZ  = 6'd29;
  localparam logic [UA_W-1:0] UA_HALT  = 6'd32;

  // Opcode values that have a routine
  localparam logic [OPC_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OP_BEQZ  = 6'd4;
  localparam logic [OPC_W-1:0] OP_BNEZ  = 6'd5;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OP_LW    = 6'd35;
  localparam logic [OPC_W-1:0] OP_SW    = 6'd43;

endpackage

// File: rtl/uc_rom.sv
module uc_rom
  import ucode_pkg::*;
#(
  parameter int unsigned AW = UA_W
) (
  input  logic [AW-1:0] addr_i,
  output uinst_t        word_o
);

  localparam int unsigned DEPTH = 2 ** AW;

  // Source/destination helpers keep each step readable
  function automatic ctrl_t rd_reg(input ctrl_t c, input rsel_e s);
    ctrl_t r = c;
    r.reg_sel = s;
    r.drv_reg = 1'b1;
    return r;
  endfunction

  function automatic ctrl_t wr_reg(input ctrl_t c, input rsel_e s);
    ctrl_t r = c;
    r.reg_sel = s;
    r.reg_wr  = 1'b1;
    return r;
  endfunction

  function automatic ctrl_t alu_out(input ctrl_t c, input alu_e op);
    ctrl_t r = c;
    r.alu_op  = op;
    r.drv_alu = 1'b1;
    return r;
  endfunction

  function automatic ctrl_t imm_out(input ctrl_t c, input logic sx);
    ctrl_t r = c;
    r.drv_imm  = 1'b1;
    r.imm_sext = sx;
    return r;
  endfunction

  function automatic ctrl_t mem_out(input ctrl_t c);
    ctrl_t r = c;
    r.mem_en  = 1'b1;
    r.drv_mem = 1'b1;
    return r;
  endfunction

  function automatic uinst_t ucode_word(input int unsigned a);
    uinst_t u;
    ctrl_t  c;
    c = '0;
    u = '0;
    u.na = NA_NEXT;
    case (a)
      // fetch: MA <- PC ; IR <- M ; A <- PC ; PC <- A+4, dispatch
      0:  begin c = rd_reg(c, RS_PC); c.ld_ma = 1'b1; end
      1:  begin c = mem_out(c); c.ld_ir = 1'b1; u.na = NA_SPIN; end
      2:  begin c = rd_reg(c, RS_PC); c.ld_a = 1'b1; end
      3:  begin c = alu_out(c, ALU_INC4); c.ld_pc = 1'b1; u.na = NA_DISP; end
      // register-register
      4:  begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      5:  begin c = rd_reg(c, RS_RT); c.ld_b = 1'b1; end
      6:  begin c = alu_out(c, ALU_FUNC); c = wr_reg(c, RS_RD); u.na = NA_FETCH; end
      // add immediate (sign extended)
      7:  begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      8:  begin c = imm_out(c, 1'b1); c.ld_b = 1'b1; end
      9:  begin c = alu_out(c, ALU_ADD); c = wr_reg(c, RS_RT); u.na = NA_FETCH; end
      // or immediate (zero extended)
      10: begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      11: begin c = imm_out(c, 1'b0); c.ld_b = 1'b1; end
      12: begin c = alu_out(c, ALU_OR); c = wr_reg(c, RS_RT); u.na = NA_FETCH; end
      // load word
      13: begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      14: begin c = imm_out(c, 1'b1); c.ld_b = 1'b1; end
      15: begin c = alu_out(c, ALU_ADD); c.ld_ma = 1'b1; end
      16: begin c = mem_out(c); c = wr_reg(c, RS_RT); u.na = NA_SPIN; end
      17: begin u.na = NA_FETCH; end
      // store word
      18: begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      19: begin c = imm_out(c, 1'b1); c.ld_b = 1'b1; end
      20: begin c = alu_out(c, ALU_ADD); c.ld_ma = 1'b1; end
      21: begin c = rd_reg(c, RS_RT); c.mem_en = 1'b1; c.mem_wr = 1'b1; u.na = NA_SPIN; end
      22: begin u.na = NA_FETCH; end
      // branch if A is zero
      23: begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      24: begin u.na = NA_BZ; u.tgt = UA_BRTK; end
      25: begin u.na = NA_FETCH; end
      // shared taken path: PC <- PC + imm*4
      26: begin c = rd_reg(c, RS_PC); c.ld_a = 1'b1; end
      27: begin c = imm_out(c, 1'b1); c.ld_b = 1'b1; end
      28: begin c = alu_out(c, ALU_BRT); c.ld_pc = 1'b1; u.na = NA_FETCH; end
      // branch if A is not zero
      29: begin c = rd_reg(c, RS_RS); c.ld_a = 1'b1; end
      30: begin u.na = NA_BNZ; u.tgt = UA_BRTK; end
      31: begin u.na = NA_FETCH; end
      // illegal opcode park and every unused word
      default: begin u.na = NA_HALT; end
    endcase
    u.cw = c;
    return u;
  endfunction

  uinst_t store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign store[g] = ucode_word(g);
  end

  assign word_o = store[addr_i];

endmodule

// File: rtl/uc_dispatch.sv
module uc_dispatch
  import ucode_pkg::*;
#(
  parameter int unsigned OW = OPC_W,
  parameter int unsigned AW = UA_W
) (
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] entry_o
);

  localparam int unsigned NOPS = 2 ** OW;

  function automatic logic [AW-1:0] entry_for(input int unsigned op);
    logic [AW-1:0] e;
    case (op)
      int'(OP_RTYPE): e = AW'(UA_RTYPE);
      int'(OP_BEQZ):  e = AW'(UA_BEQZ);
      int'(OP_BNEZ):  e = AW'(UA_BNEZ);
      int'(OP_ADDI):  e = AW'(UA_ADDI);
      int'(OP_ORI):   e = AW'(UA_ORI);
      int'(OP_LW):    e = AW'(UA_LW);
      int'(OP_SW):    e = AW'(UA_SW);
      default:        e = AW'(UA_HALT);
    endcase
    return e;
  endfunction

  logic [AW-1:0] table_q [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    assign table_q[g] = entry_for(g);
  end

  assign entry_o = table_q[opcode_i];

endmodule

// File: rtl/uc_next.sv
module uc_next
  import ucode_pkg::*;
#(
  parameter int unsigned AW = UA_W
) (
  input  logic [AW-1:0] upc_i,
  input  na_e           na_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] disp_i,
  input  logic          zero_i,
  input  logic          busy_i,
  output logic [AW-1:0] next_o
);

  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] seq;
  assign seq = upc_i + STEP;

  always_comb begin
    case (na_i)
      NA_NEXT:  next_o = seq;
      NA_SPIN:  next_o = busy_i ? upc_i : seq;
      NA_DISP:  next_o = disp_i;
      NA_BZ:    next_o = zero_i ? tgt_i : seq;
      NA_BNZ:   next_o = zero_i ? seq : tgt_i;
      NA_FETCH: next_o = AW'(UA_FETCH);
      default:  next_o = upc_i;
    endcase
  end

endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
  import ucode_pkg::*;
#(
  parameter int unsigned OW = OPC_W,
  parameter int unsigned AW = UA_W,
  parameter int unsigned CW = CW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode_i,
  input  logic          zero_i,
  input  logic          busy_i,
  output logic [CW-1:0] ctrl_o,
  output logic [AW-1:0] upc_o,
  output logic          halted_o
);

  logic [AW-1:0] upc_q;
  logic [AW-1:0] upc_d;
  logic [AW-1:0] disp_entry;
  uinst_t        cur;
  na_e           cur_na;
  logic [AW-1:0] cur_tgt;

  uc_rom #(.AW(AW)) u_rom (
    .addr_i (upc_q),
    .word_o (cur)
  );

  assign cur_na  = cur.na;
  assign cur_tgt = AW'(cur.tgt);

  uc_dispatch #(.OW(OW), .AW(AW)) u_disp (
    .opcode_i (opcode_i),
    .entry_o  (disp_entry)
  );

  uc_next #(.AW(AW)) u_next (
    .upc_i  (upc_q),
    .na_i   (cur_na),
    .tgt_i  (cur_tgt),
    .disp_i (disp_entry),
    .zero_i (zero_i),
    .busy_i (busy_i),
    .next_o (upc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= AW'(UA_FETCH);
    else     upc_q <= upc_d;
  end

  assign ctrl_o   = CW'(cur.cw);
  assign upc_o    = upc_q;
  assign halted_o = (cur_na == NA_HALT);

endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk
  import ucode_pkg::*;
#(
  parameter int unsigned AW = UA_W
) (
  input logic          clk,
  input logic          rst,
  input logic          zero_i,
  input logic          busy_i,
  input logic [AW-1:0] upc_o,
  input logic          halted_o,
  input na_e           cur_na,
  input logic [AW-1:0] cur_tgt
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) rst |=> (upc_o == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_na == NA_NEXT) |=> (upc_o == $past(upc_o) + AW'(1)));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_na == NA_SPIN && busy_i) |=> $stable(upc_o));

  // R5
  halt_stay_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> (halted_o && $stable(upc_o)));

  // R6
  bz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_na == NA_BZ && zero_i) |=> (upc_o == $past(cur_tgt)));

  // R7
  bnz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_na == NA_BNZ && !zero_i) |=> (upc_o == $past(cur_tgt)));

  // R8
  ret_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_na == NA_FETCH) |=> (upc_o == '0));

endmodule

bind uc_sequencer uc_sequencer_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .zero_i   (zero_i),
  .busy_i   (busy_i),
  .upc_o    (upc_o),
  .halted_o (halted_o),
  .cur_na   (cur_na),
  .cur_tgt  (cur_tgt)
);

// File: tb/sim_uc_sequencer.sv
`timescale 1ns/1ps
module sim_uc_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode_i = '0;
  logic        zero_i = 1'b0;
  logic        busy_i = 1'b0;
  logic [17:0] ctrl_o;
  logic [5:0]  upc_o;
  logic        halted_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uc_sequencer u0 (
    .clk      (clk),
    .rst      (rst),
    .opcode_i (opcode_i),
    .zero_i   (zero_i),
    .busy_i   (busy_i),
    .ctrl_o   (ctrl_o),
    .upc_o    (upc_o),
    .halted_o (halted_o)
  );

  // {opcode, zero, busy, expected micro-address after the edge}
  localparam int NV = 64;
  localparam logic [13:0] VEC [NV] = '{
    // fetch with busy stretch, busy ignored at 2, add-immediate
    {6'd0, 1'b0,1'b0, 6'd1}, {6'd0, 1'b0,1'b1, 6'd1}, {6'd0, 1'b0,1'b0, 6'd2},
    {6'd0, 1'b0,1'b1, 6'd3}, {6'd8, 1'b0,1'b0, 6'd7}, {6'd8, 1'b1,1'b1, 6'd8},
    {6'd8, 1'b0,1'b0, 6'd9}, {6'd8, 1'b0,1'b0, 6'd0},
    // branch if zero, taken
    {6'd4, 1'b0,1'b0, 6'd1}, {6'd4, 1'b0,1'b0, 6'd2}, {6'd4, 1'b0,1'b0, 6'd3},
    {6'd4, 1'b0,1'b0, 6'd23},{6'd4, 1'b0,1'b0, 6'd24},{6'd4, 1'b1,1'b0, 6'd26},
    {6'd4, 1'b0,1'b0, 6'd27},{6'd4, 1'b0,1'b0, 6'd28},{6'd4, 1'b0,1'b0, 6'd0},
    // branch if zero, not taken (zero ignored at 23)
    {6'd4, 1'b0,1'b0, 6'd1}, {6'd4, 1'b0,1'b0, 6'd2}, {6'd4, 1'b0,1'b0, 6'd3},
    {6'd4, 1'b0,1'b0, 6'd23},{6'd4, 1'b1,1'b0, 6'd24},{6'd4, 1'b0,1'b0, 6'd25},
    {6'd4, 1'b0,1'b0, 6'd0},
    // branch if not zero, taken
    {6'd5, 1'b0,1'b0, 6'd1}, {6'd5, 1'b0,1'b0, 6'd2}, {6'd5, 1'b0,1'b0, 6'd3},
    {6'd5, 1'b0,1'b0, 6'd29},{6'd5, 1'b0,1'b0, 6'd30},{6'd5, 1'b0,1'b0, 6'd26},
    {6'd5, 1'b0,1'b0, 6'd27},{6'd5, 1'b0,1'b0, 6'd28},{6'd5, 1'b0,1'b0, 6'd0},
    // register-register
    {6'd0, 1'b0,1'b0, 6'd1}, {6'd0, 1'b0,1'b0, 6'd2}, {6'd0, 1'b0,1'b0, 6'd3},
    {6'd0, 1'b0,1'b0, 6'd4}, {6'd0, 1'b0,1'b0, 6'd5}, {6'd0, 1'b0,1'b0, 6'd6},
    {6'd0, 1'b0,1'b0, 6'd0},
    // load word with busy on the data read
    {6'd35,1'b0,1'b0, 6'd1}, {6'd35,1'b0,1'b0, 6'd2}, {6'd35,1'b0,1'b0, 6'd3},
    {6'd35,1'b0,1'b0, 6'd13},{6'd35,1'b0,1'b0, 6'd14},{6'd35,1'b0,1'b0, 6'd15},
    {6'd35,1'b0,1'b0, 6'd16},{6'd35,1'b0,1'b1, 6'd16},{6'd35,1'b0,1'b0, 6'd17},
    {6'd35,1'b0,1'b0, 6'd0},
    // store word
    {6'd43,1'b0,1'b0, 6'd1}, {6'd43,1'b0,1'b0, 6'd2}, {6'd43,1'b0,1'b0, 6'd3},
    {6'd43,1'b0,1'b0, 6'd18},{6'd43,1'b0,1'b0, 6'd19},{6'd43,1'b0,1'b0, 6'd20},
    {6'd43,1'b0,1'b0, 6'd21},{6'd43,1'b0,1'b0, 6'd22},{6'd43,1'b0,1'b0, 6'd0},
    // unmapped opcode parks in halt
    {6'd63,1'b0,1'b0, 6'd1}, {6'd63,1'b0,1'b0, 6'd2}, {6'd63,1'b0,1'b0, 6'd3},
    {6'd63,1'b0,1'b0, 6'd32},{6'd0, 1'b1,1'b1, 6'd32}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, return at the falling edge
  task automatic step(input logic [5:0] op, input logic z, input logic b, input logic r);
    opcode_i = op;
    zero_i   = z;
    busy_i   = b;
    rst      = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_for(input logic [5:0] prev, input logic [5:0] exp);
    if (exp == 6'd0)                     return "R8";
    if (prev == 6'd3 && exp == 6'd32)    return "R5";
    if (prev == 6'd3)                    return "R4";
    if (prev == exp)                     return "R3";
    if (prev == 6'd24)                   return "R6";
    if (prev == 6'd30)                   return "R7";
    return "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    @(negedge clk);
    step(6'd0, 1'b0, 1'b0, 1'b1);
    step(6'd0, 1'b0, 1'b0, 1'b1);
    chk("R1 reset micro-address", 32'(upc_o), 32'd0);
    chk("R2 fetch step 0 bundle", 32'(ctrl_o), 32'h00088);

    prev = 6'd0;
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      step(v[13:8], v[7], v[6], 1'b0);
      chk(tag_for(prev, v[5:0]), 32'(upc_o), 32'(v[5:0]));
      prev = v[5:0];
    end

    // R5: halt holds with bundle cleared
    chk("R5 halted flag", 32'(halted_o), 32'd1);
    chk("R5 halt bundle", 32'(ctrl_o), 32'd0);
    step(6'd8, 1'b0, 1'b0, 1'b0);
    chk("R5 halt holds", 32'(upc_o), 32'd32);

    // R1: reset leaves the halt
    step(6'd0, 1'b0, 1'b0, 1'b1);
    chk("R1 reset from halt", 32'(upc_o), 32'd0);
    chk("R1 halted cleared", 32'(halted_o), 32'd0);

    // R1: reset during a busy spin
    step(6'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 fetch step 1 bundle", 32'(ctrl_o), 32'h20401);
    step(6'd0, 1'b0, 1'b1, 1'b1);
    chk("R1 reset from busy spin", 32'(upc_o), 32'd0);

    // R2/R9: or-immediate path with zero extension
    step(6'd13, 1'b0, 1'b0, 1'b0);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    chk("R2 fetch step 3 bundle", 32'(ctrl_o), 32'h04210);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    chk("R4 or-immediate dispatch", 32'(upc_o), 32'd10);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    chk("R9 zero-extend bundle", 32'(ctrl_o), 32'h00104);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    step(6'd13, 1'b0, 1'b0, 1'b0);
    chk("R8 or-immediate return", 32'(upc_o), 32'd0);

    // R9: add-immediate sign extension
    for (int k = 0; k < 5; k++) step(6'd8, 1'b0, 1'b0, 1'b0);
    chk("R9 add-immediate step", 32'(upc_o), 32'd8);
    chk("R9 sign-extend bundle", 32'(ctrl_o), 32'h02104);
    step(6'd8, 1'b0, 1'b0, 1'b0);
    step(6'd8, 1'b0, 1'b0, 1'b0);
    chk("R8 add-immediate return", 32'(upc_o), 32'd0);

    // R7: branch if not zero with zero set falls through
    for (int k = 0; k < 5; k++) step(6'd5, 1'b0, 1'b0, 1'b0);
    chk("R7 at branch step", 32'(upc_o), 32'd30);
    step(6'd5, 1'b1, 1'b0, 1'b0);
    chk("R7 not taken", 32'(upc_o), 32'd31);
    step(6'd5, 1'b0, 1'b0, 1'b0);
    chk("R8 not-taken return", 32'(upc_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule